// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a small data cache placed between a processor's load/store port and a slower, word-wide memory port. It stores one 32-bit word per line and keeps two lines (ways) per set. A request to a resident word is answered in the same cycle. A request to a word that is not resident stalls the processor while the block fetches the word from memory. If the line it must displace holds modified data, that data is first written back to memory.

The processor port is a request/stall handshake. The processor raises a request with an address, a write flag and write data. It must hold these values unchanged while the ready flag stays low. The request completes in the cycle where ready is high. The memory port works on request and acknowledge. Each transfer is closed by a single acknowledge pulse, and for a read that pulse carries the read data.

Top module: `twoway_wb_cache`

## Requirements
- R1: The address is split as follows: bits [1:0] are a byte offset that is ignored, bits [9:2] select one of 256 sets, and bits [31:10] are the tag. Two addresses that differ only in bits [1:0] reach the same cached word.
- R2: After reset no line is valid. With no request pending, ready is high, and the first access to any address is a miss.
- R3: A hit needs a valid line whose stored tag equals the address tag, with both ways checked at once. On a hit, ready is high in the same cycle, read data comes from the hitting way, and the memory port stays idle.
- R4: Two words that map to the same set can be resident together. Alternating eight accesses between byte addresses 0x000 and 0x400 gives exactly two misses.
- R5: On a miss the victim is chosen in this order: an invalid way first, with way 0 taken if both ways are invalid; otherwise the least recently referenced way. Each completed access, hit or miss, marks its way as the most recent in its set.
- R6: A write hit changes only the cached word and marks the line modified. It causes no memory write.
- R7: A miss whose victim is valid and modified first writes the victim word to memory, at the victim's own address. Only after that write is acknowledged is the refill read issued.
- R8: A miss whose victim is clean or invalid issues only the refill read, with no memory write.
- R9: A write miss allocates. The word is read from memory, the write data replaces it, and the line is marked modified. A read refill leaves the line clean.
- R10: Ready is low from the cycle a miss is seen until the response cycle. It is low for the whole of every memory transfer.
- R11: While the memory request is high and not yet acknowledged, the request, write flag, address and write data stay stable. Each transfer gets exactly one acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | Access is a write |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid when ready is high on a read |
| cpu_ready | output | 1 | High when the access completes; low means stall |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory transfer is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |
| mem_ack | input | 1 | One-cycle transfer acknowledge |

## Verification
The bench focuses on the cases where replacement order matters. A three-address conflict in one set shows whether the recency bit is updated on hits. A design that updated it only on refills would evict the word that was just re-read and miss on it next. A modified line is also forced out, and the bench checks that one memory write at the victim's address comes before the refill read. A design that dropped the write-back or ordered the two transfers wrongly would later return stale data. A write miss followed by eviction and a re-read shows whether write-allocate merged the data and set the modified flag. Random traffic confined to a few heavily shared sets is compared against a reference model of tags, recency and modified bits. That model predicts, access by access, whether the access hits and whether a write-back occurs.

// File: rtl/cwb_pkg.sv
// Package: shared types for the two-way write-back cache.
// Assumes: nothing beyond IEEE 1800-2017.
package cwb_pkg;

    // Miss-handling controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL = 2'd2,
        ST_RESP = 2'd3
    } cwb_state_e;

endpackage

// File: rtl/cwb_way.sv
// Module: one way of the cache. Holds valid, modified, tag and data for every
// set, and compares the indexed tag with the request tag.
// Assumes: lookup and write use the same set index (the request's set);
// tag and data arrays need no reset because the valid bits guard them.
module cwb_way #(
    parameter int SET_W  = 8,
    parameter int TAG_W  = 22,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  set_idx,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              hit,
    output logic              line_valid,
    output logic              line_dirty,
    output logic [TAG_W-1:0]  line_tag,
    output logic [DATA_W-1:0] line_data,
    input  logic              wr_en,
    input  logic              wr_dirty,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    // Status bits: cleared at reset, set on every line write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[set_idx] <= 1'b1;
            dirty_q[set_idx] <= wr_dirty;
        end
    end

    // Tag and data storage
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[set_idx]  <= wr_tag;
            data_q[set_idx] <= wr_data;
        end
    end

    // Read the indexed line and compare its tag
    always_comb begin
        line_valid = valid_q[set_idx];
        line_dirty = dirty_q[set_idx];
        line_tag   = tag_q[set_idx];
        line_data  = data_q[set_idx];
        hit        = line_valid && (line_tag == req_tag);
    end
endmodule

// File: rtl/cwb_recency.sv
// Module: one recency bit per set that names the least recently used way,
// plus the victim choice for a miss.
// Assumes: two ways; the touch and the lookup use the same set index.
module cwb_recency #(
    parameter int SET_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_idx,
    input  logic             touch_en,
    input  logic             touch_way,
    input  logic             valid0,
    input  logic             valid1,
    output logic             victim
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0] lru_q;

    // Mark the referenced way as most recent, so the other becomes least recent
    always_ff @(posedge clk) begin
        if (!rst_n)
            lru_q <= '0;
        else if (touch_en)
            lru_q[set_idx] <= ~touch_way;
    end

    // Victim choice: an empty way first (way 0 first), else the least recent way
    always_comb begin
        if (!valid0)
            victim = 1'b0;
        else if (!valid1)
            victim = 1'b1;
        else
            victim = lru_q[set_idx];
    end
endmodule

// File: rtl/cwb_ctrl.sv
// Module: miss controller. Idle serves hits; on a miss it runs an optional
// write-back, then a refill, then one response cycle.
// Assumes: the processor holds its request steady while stalled; the memory
// acknowledges each transfer with exactly one pulse.
module cwb_ctrl
    import cwb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_req,
    input  logic       hit_any,
    input  logic       victim_dirty,
    input  logic       mem_ack,
    output cwb_state_e state,
    output logic       miss_start
);
    cwb_state_e state_d;

    // A miss is seen in idle when a request finds no matching line
    assign miss_start = (state == ST_IDLE) && cpu_req && !hit_any;

    // Next-state selection
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:  if (miss_start) state_d = victim_dirty ? ST_WBACK : ST_FILL;
            ST_WBACK: if (mem_ack) state_d = ST_FILL;
            ST_FILL:  if (mem_ack) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_d;
    end
endmodule

// File: rtl/twoway_wb_cache.sv
// Module: two-way set-associative write-back cache with one-word lines,
// write-allocate and one recency bit per set.
// Assumes: processor holds req/we/addr/wdata while ready is low; memory
// gives one ack pulse per transfer, with read data valid alongside it.
module twoway_wb_cache
    import cwb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SET_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int OFF_W = $clog2(DATA_W / 8);
    localparam int TAG_W = ADDR_W - SET_W - OFF_W;
    localparam int WAYS  = 2;

    logic [SET_W-1:0]  set_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [OFF_W-1:0]  unused_offset;

    logic [WAYS-1:0]   hit_vec;
    logic [WAYS-1:0]   valid_vec;
    logic [WAYS-1:0]   dirty_vec;
    logic [WAYS-1:0]   wr_en_vec;
    logic [TAG_W-1:0]  tag_vec  [WAYS];
    logic [DATA_W-1:0] data_vec [WAYS];

    logic              hit_any;
    logic              hit_way;
    logic              victim;
    logic              victim_q;
    logic              victim_dirty;
    logic              miss_start;
    logic              line_wr;
    logic              line_way;
    logic              line_dirty;
    logic [DATA_W-1:0] line_data;
    cwb_state_e        state;

    // Address fields
    assign set_idx       = cpu_addr[OFF_W +: SET_W];
    assign req_tag       = cpu_addr[ADDR_W-1 -: TAG_W];
    assign unused_offset = cpu_addr[OFF_W-1:0];

    // Storage ways, one comparator each
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        cwb_way #(
            .SET_W (SET_W),
            .TAG_W (TAG_W),
            .DATA_W(DATA_W)
        ) u_way (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_idx   (set_idx),
            .req_tag   (req_tag),
            .hit       (hit_vec[w]),
            .line_valid(valid_vec[w]),
            .line_dirty(dirty_vec[w]),
            .line_tag  (tag_vec[w]),
            .line_data (data_vec[w]),
            .wr_en     (wr_en_vec[w]),
            .wr_dirty  (line_dirty),
            .wr_tag    (req_tag),
            .wr_data   (line_data)
        );
        assign wr_en_vec[w] = line_wr && (line_way == 1'(w));
    end

    assign hit_any = |hit_vec;
    assign hit_way = hit_vec[1];

    // Recency tracking and victim choice
    cwb_recency #(.SET_W(SET_W)) u_rec (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_idx  (set_idx),
        .touch_en (cpu_req && cpu_ready),
        .touch_way(hit_way),
        .valid0   (valid_vec[0]),
        .valid1   (valid_vec[1]),
        .victim   (victim)
    );

    assign victim_dirty = valid_vec[victim] && dirty_vec[victim];

    // Miss controller
    cwb_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req     (cpu_req),
        .hit_any     (hit_any),
        .victim_dirty(victim_dirty),
        .mem_ack     (mem_ack),
        .state       (state),
        .miss_start  (miss_start)
    );

    // Hold the chosen victim for the duration of the miss
    always_ff @(posedge clk) begin
        if (!rst_n)
            victim_q <= 1'b0;
        else if (miss_start)
            victim_q <= victim;
    end

    // Line write source: a write hit, or the refill (merged with write data on a write miss)
    always_comb begin
        line_wr    = 1'b0;
        line_way   = hit_way;
        line_dirty = 1'b1;
        line_data  = cpu_wdata;
        if (state == ST_FILL) begin
            line_wr    = mem_ack;
            line_way   = victim_q;
            line_dirty = cpu_we;
            line_data  = cpu_we ? cpu_wdata : mem_rdata;
        end else if ((state == ST_IDLE) || (state == ST_RESP)) begin
            line_wr = cpu_req && cpu_we && hit_any;
        end
    end

    // Processor side: stall during a miss, data through the hit-controlled select
    always_comb begin
        cpu_ready = (state == ST_RESP) || ((state == ST_IDLE) && !miss_start);
        cpu_rdata = '0;
        if (hit_vec[1])
            cpu_rdata = data_vec[1];
        else if (hit_vec[0])
            cpu_rdata = data_vec[0];
    end

    // Memory side: write-back of the held victim, then the refill read
    always_comb begin
        mem_req   = (state == ST_WBACK) || (state == ST_FILL);
        mem_we    = (state == ST_WBACK);
        mem_wdata = data_vec[victim_q];
        if (state == ST_WBACK)
            mem_addr = {tag_vec[victim_q], set_idx, {OFF_W{1'b0}}};
        else
            mem_addr = {req_tag, set_idx, {OFF_W{1'b0}}};
    end
endmodule

// File: rtl/cwb_checker.sv
// Module: protocol and structure checks for the two-way cache, bound to the top.
// Assumes: synchronous active-low reset; all checks are off while in reset.
module cwb_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic [1:0]        hit_vec
);
    // R11: an open memory transfer keeps its request fields steady
    a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    // R10: the processor is stalled whenever memory is busy
    a_r10_stall_mem: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    // R3: a request with no matching way never completes
    a_r3_miss_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && (hit_vec == 2'b00)) |-> !cpu_ready);

    // R4: a word is resident in at most one way
    a_r4_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> $onehot0(hit_vec));

    // R7: a finished write-back is followed directly by the refill read
    a_r7_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));
endmodule

bind twoway_wb_cache cwb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .cpu_ready(cpu_ready),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_ack  (mem_ack),
    .hit_vec  (hit_vec)
);

// File: tb/twoway_wb_cache_test.sv
`timescale 1ns/1ps
module twoway_wb_cache_test;
    localparam int LAT   = 3;
    localparam int MWORDS = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    twoway_wb_cache uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // Backing memory, golden processor view, and reference cache state
    logic [31:0] bmem [MWORDS];
    logic [31:0] gold [MWORDS];
    logic        m_valid [256][2];
    logic        m_dirty [256][2];
    logic [21:0] m_tag   [256][2];
    logic        m_lru   [256];

    int wr_cnt = 0, rd_cnt = 0, cyc = 0;
    int last_wr_cyc = 0, last_rd_cyc = 0;
    logic [31:0] last_wr_addr = '0;
    int hold_viol = 0;
    logic        p_open = 1'b0;
    logic [31:0] p_addr = '0, p_wdata = '0;
    logic        p_we = 1'b0;
    int lat_cnt = 0;

    function automatic logic [31:0] init_word(input int i);
        return (32'(i) * 32'h9E37_79B9) ^ 32'h5A5A_0000;
    endfunction

    // Memory model: fixed latency, one ack pulse per transfer, protocol monitor
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            mem_ack <= 1'b0;
            lat_cnt = 0;
            p_open = 1'b0;
        end else begin
            if (p_open && !(mem_req && mem_addr == p_addr && mem_we == p_we && mem_wdata == p_wdata))
                hold_viol = hold_viol + 1;
            p_open = mem_req && !mem_ack;
            p_addr = mem_addr; p_we = mem_we; p_wdata = mem_wdata;
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (lat_cnt == LAT) begin
                    lat_cnt = 0;
                    mem_ack <= 1'b1;
                    p_open = 1'b0;
                    if (mem_we) begin
                        bmem[mem_addr[12:2]] = mem_wdata;
                        wr_cnt = wr_cnt + 1;
                        last_wr_cyc = cyc;
                        last_wr_addr = mem_addr;
                    end else begin
                        mem_rdata <= bmem[mem_addr[12:2]];
                        rd_cnt = rd_cnt + 1;
                        last_rd_cyc = cyc;
                    end
                end else begin
                    lat_cnt = lat_cnt + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one access at a falling edge and wait for ready
    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output int stalls);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        stalls = 0;
        #0.5;
        while (!cpu_ready && stalls < 500) begin
            @(negedge clk);
            stalls = stalls + 1;
        end
        rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    // Reference model step: predicts hit and write-back, updates state
    task automatic model(input bit we, input logic [31:0] a, output bit hit, output bit wb);
        logic [7:0]  s;
        logic [21:0] t;
        logic        way;
        s = a[9:2]; t = a[31:10];
        hit = 1'b0; way = 1'b0; wb = 1'b0;
        for (int w = 0; w < 2; w++)
            if (m_valid[s][w] && m_tag[s][w] == t) begin hit = 1'b1; way = 1'(w); end
        if (!hit) begin
            if (!m_valid[s][0]) way = 1'b0;
            else if (!m_valid[s][1]) way = 1'b1;
            else way = m_lru[s];
            wb = m_valid[s][way] && m_dirty[s][way];
            m_valid[s][way] = 1'b1;
            m_tag[s][way] = t;
            m_dirty[s][way] = 1'b0;
        end
        if (we) m_dirty[s][way] = 1'b1;
        m_lru[s] = ~way;
    endtask

    // Access with full reference checking; returns stall count and read data
    task automatic run(input bit we, input logic [31:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output int stalls);
        bit hit, wb;
        int w0, r0;
        w0 = wr_cnt; r0 = rd_cnt;
        model(we, a, hit, wb);
        access(we, a, wd, rd, stalls);
        check((stalls == 0) == hit, "R3/R5 hit prediction", 32'(stalls), {31'd0, !hit});
        check((wr_cnt - w0) == (wb ? 1 : 0), "R7/R8 write-back count", 32'(wr_cnt - w0), wb ? 1 : 0);
        check((rd_cnt - r0) == (hit ? 0 : 1), "R6/R9 refill count", 32'(rd_cnt - r0), hit ? 0 : 1);
        if (!we) check(rd == gold[a[12:2]], "R3 read data", rd, gold[a[12:2]]);
        else gold[a[12:2]] = wd;
    endtask

    initial begin
        #1000000;
        fails = fails + 1;
        checks = checks + 1;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int st, misses, w0;
        for (int i = 0; i < MWORDS; i++) begin bmem[i] = init_word(i); gold[i] = init_word(i); end
        for (int s = 0; s < 256; s++) begin
            m_lru[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin m_valid[s][w] = 1'b0; m_dirty[s][w] = 1'b0; m_tag[s][w] = '0; end
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: idle ready after reset, first access misses
        check(cpu_ready == 1'b1, "R2 ready idle", {31'd0, cpu_ready}, 1);
        check(mem_req == 1'b0, "R2 memory idle", {31'd0, mem_req}, 0);
        run(1'b0, 32'h000, 0, rd, st);
        check(st > 0, "R2 first access misses", 32'(st), 1);

        // R4: two words in one set coexist: 2 misses in 8 accesses (first already done)
        misses = 1;
        for (int k = 1; k < 8; k++) begin
            run(1'b0, (k % 2) ? 32'h400 : 32'h000, 0, rd, st);
            if (st > 0) misses++;
        end
        check(misses == 2, "R4 ping-pong misses", 32'(misses), 2);

        // R1: byte offset ignored
        run(1'b0, 32'h403, 0, rd, st);
        check(st == 0 && rd == gold[11'h100], "R1 offset ignored", rd, gold[11'h100]);

        // R5: A,B,A,C evicts B; then A hits, B misses
        run(1'b0, 32'h004, 0, rd, st);
        run(1'b0, 32'h404, 0, rd, st);
        run(1'b0, 32'h004, 0, rd, st);
        run(1'b0, 32'h804, 0, rd, st);
        run(1'b0, 32'h004, 0, rd, st);
        check(st == 0, "R5 recent way kept", 32'(st), 0);
        run(1'b0, 32'h404, 0, rd, st);
        check(st > 0, "R5 least recent evicted", 32'(st), 1);

        // R6: write hit stays in cache
        w0 = wr_cnt;
        run(1'b1, 32'h004, 32'hCAFE_0001, rd, st);
        check(st == 0 && wr_cnt == w0, "R6 write hit no memory write", 32'(wr_cnt - w0), 0);
        check(bmem[1] == init_word(1), "R6 memory untouched", bmem[1], init_word(1));
        run(1'b0, 32'h004, 0, rd, st);
        check(rd == 32'hCAFE_0001, "R6 write hit readback", rd, 32'hCAFE_0001);

        // R9 and R7: write miss allocates dirty, eviction writes it back before refill
        run(1'b1, 32'h008, 32'hBEEF_0002, rd, st);
        check(st > 0 && bmem[2] == init_word(2), "R9 write miss allocates", bmem[2], init_word(2));
        run(1'b0, 32'h408, 0, rd, st);
        w0 = wr_cnt;
        run(1'b0, 32'h808, 0, rd, st);
        check(wr_cnt - w0 == 1 && last_wr_addr == 32'h008, "R7 write-back address", last_wr_addr, 32'h008);
        check(bmem[2] == 32'hBEEF_0002, "R7 write-back data", bmem[2], 32'hBEEF_0002);
        check(last_wr_cyc < last_rd_cyc, "R7 write before refill", 32'(last_wr_cyc), 32'(last_rd_cyc));
        check(st >= 2 * (LAT + 1), "R10 stall spans both transfers", 32'(st), 32'(2 * (LAT + 1)));
        run(1'b0, 32'h008, 0, rd, st);
        check(rd == 32'hBEEF_0002, "R9 merged data after eviction", rd, 32'hBEEF_0002);

        // R8: clean victims are not written back
        w0 = wr_cnt;
        run(1'b0, 32'h00C, 0, rd, st);
        run(1'b0, 32'h40C, 0, rd, st);
        run(1'b0, 32'h80C, 0, rd, st);
        check(wr_cnt == w0, "R8 clean eviction silent", 32'(wr_cnt - w0), 0);

        // Random mix across four heavily shared sets
        void'($urandom(32'd1234));
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a;
            bit we;
            a = ({29'd0, 3'($urandom % 8)} << 10) | ({30'd0, 2'($urandom % 4)} << 2) | 32'($urandom % 4);
            we = ($urandom % 3) == 0;
            run(we, a, $urandom, rd, st);
        end

        // R11: memory request fields held until acknowledged
        check(hold_viol == 0, "R11 memory hold", 32'(hold_viol), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule